// File: doc/BRIEF.md
# Three-Channel Byte FIFO Serializer

The block drives three serial transmit lines. Every channel owns a small byte queue and a shift stage that puts bits onto its line most significant bit first, one bit for each pulse of an external bit-rate strobe. Software loads bytes one at a time. A select code steers each load, or a single-channel start, to one channel. A global start launches every loaded channel in the same cycle. A global reinit empties all queues, drops every flag and stops every shift stage.

At each start the channel captures a frame length in bits. It keeps pulling bytes from its queue until that many bits have gone out, so software may refill the queue during a transfer and send frames longer than the queue. Each channel reports its queue occupancy as a code, a sticky overrun flag, a sticky underrun flag, and a busy bit. The busy bit covers both the reinit settling window and an unfinished frame.

Top module: `txser_bank`

## Requirements
- R1: After reset, every occupancy code, overrun flag, underrun flag, busy bit and line output reads 0.
- R2: A load (`wr_en`) with `ch_sel` equal to 0, 1 or 2 appends the byte to that channel's queue, and select code 3 changes nothing. Channel i's occupancy sits at `fifo_lvl[3i+2:3i]`: 0 means empty, 1 to 3 give the byte count, 4 means full. Codes 5 to 7 never appear.
- R3: A load into a full queue is dropped, leaving the stored bytes unchanged, and sets that channel's sticky overrun flag. A load in the same cycle as a byte fetch from a full queue is accepted.
- R4: Bits leave each byte MSB first. A line changes only on a cycle where `bit_tick` is high.
- R5: With `swap_bits` high at load time, the byte is stored bit-reversed, so its bit 0 is sent first.
- R6: `go_one` starts the selected channel and `go_all` starts all three channels. A channel does not start if its queue is empty, if `frame_len` is 0, or if it is already running.
- R7: A started channel sends exactly `frame_len` bits, fetching a new byte whenever the previous one is used up. Its busy bit is 1 from the cycle after the start until the tick that drives the last bit, then 0. Frames longer than 32 bits work when the queue is refilled in time.
- R8: If a byte is needed while frame bits remain and the queue is empty, the sticky underrun flag is set, the line holds its value, and the frame resumes when a byte arrives.
- R9: `reinit` clears all queues, flags, shift stages and lines. All busy bits then read 1 for 4 cycles and 0 afterwards. Loads and starts issued during that window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte load strobe |
| wr_data | input | 8 | Byte to load |
| ch_sel | input | 2 | Channel select for load and single start; 3 selects nothing |
| swap_bits | input | 1 | Store the loaded byte bit-reversed |
| go_one | input | 1 | Start the selected channel |
| go_all | input | 1 | Start all channels |
| frame_len | input | 16 | Frame length in bits, captured at start |
| reinit | input | 1 | Return every channel to its default state |
| bit_tick | input | 1 | Bit-rate strobe; one bit per high cycle |
| tx_line | output | 3 | Serial data line per channel |
| fifo_lvl | output | 9 | Occupancy code per channel, 3 bits each |
| overrun | output | 3 | Sticky overrun flag per channel |
| underrun | output | 3 | Sticky underrun flag per channel |
| busy | output | 3 | Reinit settling or frame in progress, per channel |

## Verification
The bench fills one queue past full. A design that overwrote stored bytes or wrapped the count would then send the wrong stream or report an illegal occupancy code. It drains a queue during a two-byte frame to catch an underrun that is missed, or one that corrupts the line instead of holding it. It also runs a 40-bit frame with a refill partway through to catch a frame counter that stops at the queue size. Starts on an empty queue and with a zero length are checked to stay idle. The reinit window is timed to the cycle, and a load is issued inside it to show that loads are ignored there.

// File: rtl/txser_pkg.sv
package txser_pkg;
    typedef enum logic [1:0] {
        SEL_CH0  = 2'd0,
        SEL_CH1  = 2'd1,
        SEL_CH2  = 2'd2,
        SEL_NONE = 2'd3
    } chsel_e;

    localparam int DEF_NUM_CH   = 3;
    localparam int DEF_DEPTH    = 4;
    localparam int DEF_BYTE_W   = 8;
    localparam int DEF_LEN_W    = 16;
    localparam int DEF_REINIT_C = 4;
endpackage

// File: rtl/txser_fifo.sv
module txser_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     rd_data,
    output logic [CNT_W-1:0] level,
    output logic             empty,
    output logic             overrun
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
        logic                    ovr;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     accept;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        accept = push && ((st_q.cnt != CNT_W'(DEPTH)) || pop);
        if (pop) begin
            st_d.rd = ptr_next(st_q.rd);
        end
        if (accept) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = ptr_next(st_q.wr);
        end
        if (push && !accept) begin
            st_d.ovr = 1'b1;
        end
        st_d.cnt = st_q.cnt + CNT_W'(accept) - CNT_W'(pop);
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.mem[st_q.rd];
    assign level   = st_q.cnt;
    assign empty   = (st_q.cnt == '0);
    assign overrun = st_q.ovr;
endmodule

// File: rtl/txser_shift.sv
module txser_shift #(
    parameter int W     = 8,
    parameter int LEN_W = 16,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             go,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             bit_tick,
    input  logic             fifo_empty,
    input  logic [W-1:0]     fifo_data,
    output logic             pop,
    output logic             line,
    output logic             active,
    output logic             underrun
);
    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] left;
        logic [W-1:0]     sh;
        logic [CW-1:0]    sh_cnt;
        logic             line;
        logic             unr;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (go && !st_q.active && !fifo_empty && (frame_len != '0)) begin
            st_d.active = 1'b1;
            st_d.left   = frame_len;
            st_d.sh_cnt = '0;
        end else if (st_q.active && bit_tick) begin
            if (st_q.sh_cnt == '0) begin
                if (fifo_empty) begin
                    st_d.unr = 1'b1;
                end else begin
                    pop         = 1'b1;
                    st_d.line   = fifo_data[W-1];
                    st_d.sh     = {fifo_data[W-2:0], 1'b0};
                    st_d.sh_cnt = CW'(W - 1);
                    st_d.left   = st_q.left - 1'b1;
                    if (st_q.left == LEN_W'(1)) begin
                        st_d.active = 1'b0;
                    end
                end
            end else begin
                st_d.line   = st_q.sh[W-1];
                st_d.sh     = {st_q.sh[W-2:0], 1'b0};
                st_d.sh_cnt = st_q.sh_cnt - 1'b1;
                st_d.left   = st_q.left - 1'b1;
                if (st_q.left == LEN_W'(1)) begin
                    st_d.active = 1'b0;
                end
            end
        end
        if (clr) begin
            st_d = '0;
            pop  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line     = st_q.line;
    assign active   = st_q.active;
    assign underrun = st_q.unr;
endmodule

// File: rtl/txser_ctrl.sv
module txser_ctrl #(
    parameter int NUM_CH   = 3,
    parameter int SEL_W    = 2,
    parameter int REINIT_C = 4,
    localparam int RC_W    = $clog2(REINIT_C + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  ch_sel,
    input  logic              go_one,
    input  logic              go_all,
    input  logic              reinit,
    output logic [NUM_CH-1:0] wr_vec,
    output logic [NUM_CH-1:0] go_vec,
    output logic              clr,
    output logic              reinit_busy
);
    typedef struct packed {
        logic [RC_W-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     hold;

    always_comb begin
        st_d = st_q;
        hold = (st_q.cnt != '0);
        clr  = reinit;
        if (reinit) begin
            st_d.cnt = RC_W'(REINIT_C);
        end else if (hold) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            wr_vec[i] = wr_en && (ch_sel == SEL_W'(i)) && !hold && !reinit;
            go_vec[i] = (go_all || (go_one && (ch_sel == SEL_W'(i)))) && !hold && !reinit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reinit_busy = (st_q.cnt != '0);
endmodule

// File: rtl/txser_bank.sv
module txser_bank
    import txser_pkg::*;
#(
    parameter int NUM_CH   = DEF_NUM_CH,
    parameter int DEPTH    = DEF_DEPTH,
    parameter int BYTE_W   = DEF_BYTE_W,
    parameter int LEN_W    = DEF_LEN_W,
    parameter int REINIT_C = DEF_REINIT_C,
    localparam int SEL_W   = $clog2(NUM_CH + 1),
    localparam int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [BYTE_W-1:0]       wr_data,
    input  logic [SEL_W-1:0]        ch_sel,
    input  logic                    swap_bits,
    input  logic                    go_one,
    input  logic                    go_all,
    input  logic [LEN_W-1:0]        frame_len,
    input  logic                    reinit,
    input  logic                    bit_tick,
    output logic [NUM_CH-1:0]       tx_line,
    output logic [NUM_CH*LVL_W-1:0] fifo_lvl,
    output logic [NUM_CH-1:0]       overrun,
    output logic [NUM_CH-1:0]       underrun,
    output logic [NUM_CH-1:0]       busy
);
    logic [NUM_CH-1:0] wr_vec;
    logic [NUM_CH-1:0] go_vec;
    logic              clr;
    logic              reinit_busy;
    logic [BYTE_W-1:0] data_rev;
    logic [BYTE_W-1:0] load_byte;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_rev
        assign data_rev[b] = wr_data[BYTE_W-1-b];
    end
    assign load_byte = swap_bits ? data_rev : wr_data;

    txser_ctrl #(
        .NUM_CH   (NUM_CH),
        .SEL_W    (SEL_W),
        .REINIT_C (REINIT_C)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .ch_sel      (ch_sel),
        .go_one      (go_one),
        .go_all      (go_all),
        .reinit      (reinit),
        .wr_vec      (wr_vec),
        .go_vec      (go_vec),
        .clr         (clr),
        .reinit_busy (reinit_busy)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [BYTE_W-1:0] head;
        logic              empty;
        logic              pop;
        logic              active;

        txser_fifo #(
            .DEPTH (DEPTH),
            .W     (BYTE_W)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .push      (wr_vec[c]),
            .push_data (load_byte),
            .pop       (pop),
            .rd_data   (head),
            .level     (fifo_lvl[c*LVL_W +: LVL_W]),
            .empty     (empty),
            .overrun   (overrun[c])
        );

        txser_shift #(
            .W     (BYTE_W),
            .LEN_W (LEN_W)
        ) u_shift (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (clr),
            .go         (go_vec[c]),
            .frame_len  (frame_len),
            .bit_tick   (bit_tick),
            .fifo_empty (empty),
            .fifo_data  (head),
            .pop        (pop),
            .line       (tx_line[c]),
            .active     (active),
            .underrun   (underrun[c])
        );

        assign busy[c] = active | reinit_busy;
    end
endmodule

// File: rtl/txser_bank_chk.sv
module txser_bank_chk #(
    parameter int NUM_CH = 3,
    parameter int DEPTH  = 4,
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 16,
    localparam int SEL_W = $clog2(NUM_CH + 1),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [BYTE_W-1:0]       wr_data,
    input logic [SEL_W-1:0]        ch_sel,
    input logic                    swap_bits,
    input logic                    go_one,
    input logic                    go_all,
    input logic [LEN_W-1:0]        frame_len,
    input logic                    reinit,
    input logic                    bit_tick,
    input logic [NUM_CH-1:0]       tx_line,
    input logic [NUM_CH*LVL_W-1:0] fifo_lvl,
    input logic [NUM_CH-1:0]       overrun,
    input logic [NUM_CH-1:0]       underrun,
    input logic [NUM_CH-1:0]       busy
);
    a_r4_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !reinit) |=> $stable(tx_line));

    a_r9_reinit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (busy == '1 && fifo_lvl == '0 && overrun == '0
                    && underrun == '0 && tx_line == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic [LVL_W-1:0] lv;
        assign lv = fifo_lvl[i*LVL_W +: LVL_W];

        a_r2_lvl_legal: assert property (@(posedge clk) disable iff (!rst_n)
            lv <= LVL_W'(DEPTH));

        a_r3_ovr_when_full: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(overrun[i]) |-> $past(lv) == LVL_W'(DEPTH));

        a_r8_unr_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(underrun[i]) |-> ($past(lv) == '0 && $past(busy[i])));

        a_r6_empty_no_start: assert property (@(posedge clk) disable iff (!rst_n)
            (lv == '0 && !busy[i] && !reinit) |=> !busy[i]);
    end
endmodule

bind txser_bank txser_bank_chk #(
    .NUM_CH (NUM_CH),
    .DEPTH  (DEPTH),
    .BYTE_W (BYTE_W),
    .LEN_W  (LEN_W)
) u_chk (.*);

// File: tb/txser_bank_bench.sv
module txser_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  ch_sel = '0;
    logic        swap_bits = 1'b0;
    logic        go_one = 1'b0;
    logic        go_all = 1'b0;
    logic [15:0] frame_len = '0;
    logic        reinit = 1'b0;
    logic        bit_tick = 1'b0;
    logic [2:0]  tx_line;
    logic [8:0]  fifo_lvl;
    logic [2:0]  overrun;
    logic [2:0]  underrun;
    logic [2:0]  busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    txser_bank u_txser_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ch_sel    (ch_sel),
        .swap_bits (swap_bits),
        .go_one    (go_one),
        .go_all    (go_all),
        .frame_len (frame_len),
        .reinit    (reinit),
        .bit_tick  (bit_tick),
        .tx_line   (tx_line),
        .fifo_lvl  (fifo_lvl),
        .overrun   (overrun),
        .underrun  (underrun),
        .busy      (busy)
    );

    // {sel, data, expected levels as octal ch2 ch1 ch0, expected overrun}
    localparam logic [21:0] VEC [8] = '{
        {2'd0, 8'hA5, 9'o001, 3'b000},
        {2'd1, 8'h3C, 9'o011, 3'b000},
        {2'd2, 8'h0F, 9'o111, 3'b000},
        {2'd3, 8'h77, 9'o111, 3'b000},
        {2'd0, 8'h11, 9'o112, 3'b000},
        {2'd0, 8'h22, 9'o113, 3'b000},
        {2'd0, 8'h33, 9'o114, 3'b000},
        {2'd0, 8'h44, 9'o114, 3'b001}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] ch, input logic [7:0] d);
        wr_en = 1'b1; ch_sel = ch; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_go(input bit all, input logic [1:0] ch, input logic [15:0] len);
        go_one = !all; go_all = all; ch_sel = ch; frame_len = len;
        @(negedge clk);
        go_one = 1'b0; go_all = 1'b0;
    endtask

    task automatic do_tick(output logic [2:0] b);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        b = tx_line;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R7 actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [2:0]  b;
        logic [39:0] g0;
        logic [7:0]  g1;
        logic [7:0]  g2;
        logic [2:0]  held;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({fifo_lvl, overrun, underrun, busy, tx_line} == '0, "R1 reset state",
            {fifo_lvl, overrun, underrun, busy, tx_line}, 0);

        // R2 / R3 load table
        for (int k = 0; k < 8; k++) begin
            do_write(VEC[k][21:20], VEC[k][19:12]);
            chk(fifo_lvl == VEC[k][11:3], "R2 occupancy after load", fifo_lvl, VEC[k][11:3]);
            chk(overrun == VEC[k][2:0], "R3 overrun flag", overrun, VEC[k][2:0]);
        end

        // R6 single start of channel 0
        do_go(1'b0, 2'd0, 16'd32);
        chk(busy == 3'b001, "R6 single start busy", busy, 3'b001);
        held = tx_line;
        repeat (3) @(negedge clk);
        chk(tx_line == held, "R4 line stable without tick", tx_line, held);

        g0 = '0;
        for (int k = 0; k < 32; k++) begin
            do_tick(b);
            g0 = {g0[38:0], b[0]};
            if (k == 30) chk(busy[0] == 1'b1, "R7 busy before last bit", busy, 1);
        end
        chk(g0[31:0] == 32'hA5112233, "R3 R4 stream MSB first, dropped byte absent", g0[31:0], 32'hA5112233);
        chk(busy == 3'b000, "R7 busy clears after last bit", busy, 0);
        chk(fifo_lvl == 9'o110, "R7 queue drained", fifo_lvl, 9'o110);

        // R6 global start; channel 0 empty stays idle
        do_go(1'b1, 2'd3, 16'd8);
        chk(busy == 3'b110, "R6 global start skips empty", busy, 3'b110);
        g1 = '0; g2 = '0;
        for (int k = 0; k < 8; k++) begin
            do_tick(b);
            g1 = {g1[6:0], b[1]};
            g2 = {g2[6:0], b[2]};
        end
        chk(g1 == 8'h3C, "R6 channel 1 byte", g1, 8'h3C);
        chk(g2 == 8'h0F, "R6 channel 2 byte", g2, 8'h0F);
        chk(busy == 3'b000, "R7 global frames done", busy, 0);

        // R9 reinit
        do_write(2'd0, 8'h5A);
        do_write(2'd0, 8'h5A);
        reinit = 1'b1;
        @(negedge clk);
        reinit = 1'b0;
        chk(busy == 3'b111, "R9 busy during reinit", busy, 3'b111);
        chk({fifo_lvl, overrun, underrun, tx_line} == '0, "R9 state cleared",
            {fifo_lvl, overrun, underrun, tx_line}, 0);
        do_write(2'd1, 8'hAA);
        chk(fifo_lvl == '0, "R9 load ignored during reinit", fifo_lvl, 0);
        repeat (2) @(negedge clk);
        chk(busy == 3'b111, "R9 busy in fourth cycle", busy, 3'b111);
        @(negedge clk);
        chk(busy == 3'b000, "R9 busy ends after four cycles", busy, 0);

        // R5 bit reversal at load
        swap_bits = 1'b1;
        do_write(2'd2, 8'h01);
        swap_bits = 1'b0;
        do_go(1'b0, 2'd2, 16'd8);
        g2 = '0;
        for (int k = 0; k < 8; k++) begin
            do_tick(b);
            g2 = {g2[6:0], b[2]};
        end
        chk(g2 == 8'h80, "R5 swapped byte", g2, 8'h80);

        // R8 underrun and resume
        do_write(2'd1, 8'hF0);
        do_go(1'b0, 2'd1, 16'd16);
        g1 = '0;
        for (int k = 0; k < 8; k++) begin
            do_tick(b);
            g1 = {g1[6:0], b[1]};
        end
        chk(g1 == 8'hF0, "R8 first byte", g1, 8'hF0);
        chk(underrun == 3'b000, "R8 no underrun before need", underrun, 0);
        do_tick(b);
        chk(underrun == 3'b010, "R8 underrun set", underrun, 3'b010);
        chk(b[1] == 1'b0, "R8 line holds", b[1], 0);
        chk(busy[1] == 1'b1, "R8 still busy", busy, 3'b010);
        do_write(2'd1, 8'hFF);
        g1 = '0;
        for (int k = 0; k < 8; k++) begin
            do_tick(b);
            g1 = {g1[6:0], b[1]};
        end
        chk(g1 == 8'hFF, "R8 resumed byte", g1, 8'hFF);
        chk(busy[1] == 1'b0, "R8 frame done", busy, 0);

        // R7 continuous 40-bit frame
        do_write(2'd0, 8'h81);
        do_write(2'd0, 8'h42);
        do_write(2'd0, 8'h24);
        do_write(2'd0, 8'h18);
        do_go(1'b0, 2'd0, 16'd40);
        g0 = '0;
        for (int k = 0; k < 8; k++) begin
            do_tick(b);
            g0 = {g0[38:0], b[0]};
        end
        chk(fifo_lvl[2:0] == 3'd3, "R7 one byte fetched", fifo_lvl[2:0], 3);
        do_write(2'd0, 8'hC3);
        for (int k = 0; k < 32; k++) begin
            do_tick(b);
            g0 = {g0[38:0], b[0]};
        end
        chk(g0 == 40'h81422418C3, "R7 40-bit frame", g0, 40'h81422418C3);
        chk(underrun[0] == 1'b0 && busy[0] == 1'b0, "R7 clean end", {underrun, busy}, 0);
        held = tx_line;
        do_tick(b);
        chk(b == held, "R7 no bit after frame end", b, held);

        // R6 refused starts
        do_go(1'b0, 2'd0, 16'd16);
        chk(busy == 3'b000, "R6 empty queue refused", busy, 0);
        do_write(2'd0, 8'h99);
        do_go(1'b0, 2'd0, 16'd0);
        chk(busy == 3'b000, "R6 zero length refused", busy, 0);
        chk(fifo_lvl[2:0] == 3'd1, "R6 queue kept", fifo_lvl[2:0], 1);
        do_go(1'b0, 2'd3, 16'd8);
        chk(busy == 3'b000, "R2 select 3 starts nothing", busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule